// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it samples the active-low strobes (chip select, row strobe, column strobe, write enable), the clock-enable level, a two-bit bank select and the row/auto-precharge address bus. It decodes activate, read, write, precharge and auto-refresh. For each of four banks it keeps an open/closed flag and the row that was last opened.

Downstream logic receives one registered strobe per accepted command. The block also raises a one-cycle illegal flag when a command does not fit the current bank state. Address bit 10 changes what a command means. On a precharge it widens the command to every bank. On a read or write it closes the bank by itself once a burst of `BURST_LEN` cycles has run out.

All outputs are registered. A command sampled at edge N is reflected in the strobes and in the bank state from just after edge N. Reset is asynchronous and active low. Its release is synchronised inside the block, so the first command is accepted on the third rising edge after `rst_n` goes high.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n`=0, the pattern `ras_n`=0, `cas_n`=1, `we_n`=1 is an activate. When the addressed bank is closed, the block pulses `act_stb` for one cycle, sets `bank_active[ba]` and stores `addr[12:0]` in field `ba` of `open_row`, which is bits [13*ba+12 : 13*ba].
- R2: With `cs_n`=0, `ras_n`=1, `cas_n`=0 is a column command. It is a read when `we_n`=1 (pulses `rd_stb`) and a write when `we_n`=0 (pulses `wr_stb`). It is accepted only when the addressed bank is open.
- R3: The row stored for a bank is the address presented with its accepted activate, for any value including an all-ones row. A rejected activate leaves the stored row unchanged.
- R4: The pattern `ras_n`=0, `cas_n`=1, `we_n`=0 is a precharge and is always accepted (`pre_stb`). With `addr[10]`=0 it closes only bank `ba`, and a closed bank stays closed. With `addr[10]`=1 it closes all four banks.
- R5: A read or write accepted with `addr[10]`=1 at edge E leaves its bank open through edges E+1 to E+BURST_LEN-1. The bank is closed from edge E+BURST_LEN onward.
- R6: The pattern `ras_n`=0, `cas_n`=0, `we_n`=1 with `cke`=1 is an auto-refresh. It pulses `ref_stb` only when all banks are closed and otherwise raises `illegal`. With `cke`=0 the same pattern produces no strobe and no illegal flag.
- R7: With `cs_n`=1, or with any other pattern such as all three strobes high or all three low, the block produces no strobe and no illegal flag, and the bank flags do not change.
- R8: An activate to an open bank, or a read or write to a closed bank, raises `illegal` for one cycle. It produces no command strobe and leaves that bank's flag and row unchanged.
- R9: At most one of the five strobes and `illegal` is high in any cycle.
- R10: A command sampled at the edge where an auto-precharge completes is judged against the bank still being open. An activate to that bank at that edge is illegal, and the same activate one edge later is accepted.
- R11: While reset is held, all bank flags, all stored rows, all strobes and `illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock-enable level, qualifies refresh |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address; bit 10 is the precharge/auto-precharge option |
| act_stb | output | 1 | Accepted activate |
| rd_stb | output | 1 | Accepted read |
| wr_stb | output | 1 | Accepted write |
| pre_stb | output | 1 | Accepted precharge |
| ref_stb | output | 1 | Accepted auto-refresh |
| illegal | output | 1 | Command rejected for the current bank state |
| bank_active | output | 4 | Per-bank open flag |
| open_row | output | 52 | Stored row per bank, 13 bits per bank |

## Verification
The two functions that can fall on the same edge are the auto-precharge countdown closing a bank and a new command addressed to that bank. The bench provokes this by issuing a write with auto-precharge, padding with exactly BURST_LEN-1 idle cycles, and then issuing an activate to the same bank. It judges the result by checking that this activate raises `illegal` with `act_stb` low, that the bank reads closed afterwards, and that a repeat activate on the next edge is accepted with its new row stored.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_NONE;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic             active_d;
  logic [ROW_W-1:0] row_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             row_en;

  always_comb begin
    active_d = active_o;
    cnt_d    = cnt_q;
    row_en   = 1'b0;
    row_d    = row_i;
    if (close_i) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (act_i) begin
      active_d = 1'b1;
      row_en   = 1'b1;
    end else if (rw_i && ap_i) begin
      cnt_d = CNT_W'(BURST_LEN);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
      row_o    <= '0;
    end else begin
      active_o <= active_d;
      cnt_q    <= cnt_d;
      if (row_en) row_o <= row_d;
    end
  end

  p_open_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (active_o && row_o == $past(row_i)));

  p_ap_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !close_i && !act_i) |=> !active_o);

  p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |=> !active_o);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       cke,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic [ROW_W-1:0]           addr,
  output logic                       act_stb,
  output logic                       rd_stb,
  output logic                       wr_stb,
  output logic                       pre_stb,
  output logic                       ref_stb,
  output logic                       illegal,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_row
);
  localparam int BA_W = $clog2(NUM_BANKS);

  logic [1:0] rst_sync;
  logic       rst_q;
  cmd_e       cmd_w;
  logic       sel_active, all_idle, accept, ap_bit;
  logic [5:0] stb_d, stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  sdram_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n (we_n), .cke  (cke),   .cmd  (cmd_w)
  );

  assign sel_active = bank_active[ba];
  assign all_idle   = (bank_active == '0);
  assign ap_bit     = addr[AP_BIT];

  always_comb begin
    unique case (cmd_w)
      CMD_ACT:        accept = !sel_active;
      CMD_RD, CMD_WR: accept = sel_active;
      CMD_PRE:        accept = 1'b1;
      CMD_REF:        accept = all_idle;
      default:        accept = 1'b0;
    endcase
    stb_d = {cmd_w == CMD_ACT && accept,
             cmd_w == CMD_RD  && accept,
             cmd_w == CMD_WR  && accept,
             cmd_w == CMD_PRE,
             cmd_w == CMD_REF && accept,
             cmd_w != CMD_NONE && !accept};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) stb_q <= '0;
    else        stb_q <= stb_d;
  end
  assign {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, illegal} = stb_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));
    sdram_bank_slot #(.ROW_W(ROW_W), .BURST_LEN(BURST_LEN)) u_slot (
      .clk     (clk),
      .rst_n   (rst_q),
      .act_i   (cmd_w == CMD_ACT && accept && hit),
      .close_i (cmd_w == CMD_PRE && (ap_bit || hit)),
      .rw_i    ((cmd_w == CMD_RD || cmd_w == CMD_WR) && accept && hit),
      .ap_i    (ap_bit),
      .row_i   (addr),
      .active_o(bank_active[b]),
      .row_o   (open_row[b*ROW_W +: ROW_W])
    );
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, illegal}));

  p_desel_r7: assert property (@(posedge clk) disable iff (!rst_q)
    cs_n |=> !(act_stb || rd_stb || wr_stb || pre_stb || ref_stb || illegal));

  p_act_busy_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_w == CMD_ACT && sel_active) |=> (illegal && !act_stb));

  p_rw_idle_r2: assert property (@(posedge clk) disable iff (!rst_q)
    ((cmd_w == CMD_RD || cmd_w == CMD_WR) && !sel_active) |=> (illegal && !rd_stb && !wr_stb));

  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_w == CMD_PRE && ap_bit) |=> (bank_active == '0));

  p_ref_idle_r6: assert property (@(posedge clk) disable iff (!rst_q)
    ref_stb |-> (bank_active == '0));
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        act_stb, rd_stb, wr_stb, pre_stb, ref_stb, illegal;
  logic [3:0]  bank_active;
  logic [51:0] open_row;

  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
    .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
    .ref_stb(ref_stb), .illegal(illegal), .bank_active(bank_active),
    .open_row(open_row)
  );

  // ctl = {cs_n, ras_n, cas_n, we_n, cke}
  localparam logic [4:0] C_NOP = 5'b01111, C_ACT = 5'b00111, C_RD  = 5'b01011,
                         C_WR  = 5'b01001, C_PRE = 5'b00101, C_REF = 5'b00011,
                         C_DSA = 5'b10111, C_RF0 = 5'b00010, C_ALL0 = 5'b00001;

  // {ctl, ba, addr, expected {act,rd,wr,pre,ref,ill}, expected bank_active}
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {C_NOP,  2'd0, 13'h0000, 6'b000000, 4'b0000},
    {C_ACT,  2'd0, 13'h0123, 6'b100000, 4'b0001},
    {C_ACT,  2'd2, 13'h1ABC, 6'b100000, 4'b0101},
    {C_RD,   2'd0, 13'h0000, 6'b010000, 4'b0101},
    {C_WR,   2'd2, 13'h0000, 6'b001000, 4'b0101},
    {C_RD,   2'd1, 13'h0000, 6'b000001, 4'b0101},
    {C_ACT,  2'd0, 13'h0055, 6'b000001, 4'b0101},
    {C_REF,  2'd0, 13'h0000, 6'b000001, 4'b0101},
    {C_DSA,  2'd1, 13'h0011, 6'b000000, 4'b0101},
    {C_PRE,  2'd0, 13'h0000, 6'b000100, 4'b0100},
    {C_PRE,  2'd1, 13'h0000, 6'b000100, 4'b0100},
    {C_ACT,  2'd3, 13'h0777, 6'b100000, 4'b1100},
    {C_PRE,  2'd0, 13'h0400, 6'b000100, 4'b0000},
    {C_RF0,  2'd0, 13'h0000, 6'b000000, 4'b0000},
    {C_REF,  2'd0, 13'h0000, 6'b000010, 4'b0000},
    {C_ALL0, 2'd0, 13'h0000, 6'b000000, 4'b0000},
    {C_WR,   2'd3, 13'h0000, 6'b000001, 4'b0000}
  };

  function automatic logic [5:0] stbs();
    return {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, illegal};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [1:0] b, input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n, cke} = c;
    ba = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n, cke} = C_NOP;
    ba = '0;
    addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n, cke} = C_NOP;
    ba = '0;
    addr = '0;
    @(negedge clk);
    // R11 reset state
    check("R11 outputs in reset", {stbs(), bank_active}, 64'h0);
    check("R11 rows in reset", open_row, 64'h0);
    do_reset();

    // Table: R1 R2 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29:25], VEC[i][24:23], VEC[i][22:10]);
      check($sformatf("R1 R2 R4 R6 R7 R8 R9 vector %0d", i),
            {stbs(), bank_active}, {VEC[i][9:4], VEC[i][3:0]});
    end
    // rows survive rejections (R3/R8): bank0 row 0x123, bank2 row 0x1ABC, bank3 0x777
    check("R8 rejected act keeps row", open_row[12:0], 13'h0123);
    check("R3 bank2 row", open_row[38:26], 13'h1ABC);
    check("R3 bank3 row", open_row[51:39], 13'h0777);

    // R3: all-ones row and a row with bit 10 set
    drive(C_ACT, 2'd3, 13'h1FFF);
    check("R3 all-ones row", open_row[51:39], 13'h1FFF);
    drive(C_ACT, 2'd0, 13'h0400);
    check("R3 row with bit10", open_row[12:0], 13'h0400);
    check("R3 both banks open", bank_active, 4'b1001);
    drive(C_PRE, 2'd0, 13'h0400);

    // R5: read with auto-precharge on bank1, BURST_LEN = 4
    drive(C_ACT, 2'd1, 13'h0ABC);
    drive(C_RD, 2'd1, 13'h0400);
    check("R5 rd strobe", stbs(), 6'b010000);
    for (int k = 1; k < 4; k++) begin
      drive(C_NOP, 2'd0, 13'h0000);
      check($sformatf("R5 open after %0d edges", k), bank_active[1], 1'b1);
    end
    drive(C_NOP, 2'd0, 13'h0000);
    check("R5 closed at edge BURST_LEN", bank_active[1], 1'b0);

    // R10: collision of auto-precharge completion and activate
    drive(C_ACT, 2'd2, 13'h0101);
    drive(C_WR, 2'd2, 13'h0400);
    check("R10 wr strobe", stbs(), 6'b001000);
    repeat (3) drive(C_NOP, 2'd0, 13'h0000);
    drive(C_ACT, 2'd2, 13'h0202);
    check("R10 colliding act illegal", stbs(), 6'b000001);
    check("R10 bank closed", bank_active[2], 1'b0);
    check("R10 row unchanged", open_row[38:26], 13'h0101);
    drive(C_ACT, 2'd2, 13'h0202);
    check("R10 retry accepted", {stbs(), bank_active[2]}, {6'b100000, 1'b1});
    check("R10 retry row", open_row[38:26], 13'h0202);

    // R6: refresh with one bank open is rejected, state kept
    drive(C_REF, 2'd0, 13'h0000);
    check("R6 refresh rejected", {stbs(), bank_active}, {6'b000001, 4'b0100});

    // R7: deselect with write pattern does nothing
    drive(5'b11001, 2'd2, 13'h0000);
    check("R7 deselected write", {stbs(), bank_active}, {6'b000000, 4'b0100});

    // R11: asynchronous reset clears open state
    rst_n = 1'b0;
    #1;
    check("R11 async clear", {stbs(), bank_active}, 64'h0);
    check("R11 rows cleared", open_row, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule